// File: doc/BRIEF.md
# Compressed Instruction Mode Sequencer

This block sits after instruction fetch and before decode. It receives an instruction stream that mixes full 32-bit words with 16-bit compressed halfwords, one halfword per cycle over a valid/ready handshake. It works out where each instruction starts and ends, and which encoding mode each instruction belongs to. Each instruction leaves on a registered output with its length (16 or 32 bits), its class and the instruction bits. A 32-bit word is built from two halfwords in the order they arrive.

The encoding mode is driven by two control bits in each compressed halfword. Bits are numbered 0 to 15 with bit 0 the most significant, so bit 0 is `in_data[15]` and bit 15 is `in_data[0]`.

- The continuation bit M is bit 15.
- The extension bit N is bit 0, and has that meaning only in 16-bit mode.
- The compressed sub-opcode sits in bits 5 to 7 (`in_data[10:8]`). The sub-opcodes 000 and 111 are exempt from mode switching.

In standard mode, a halfword is compressed when its top five bits equal the parameter `CMAJ_OP`. The `flush` input returns the sequencer to standard mode, as a taken branch or redirect would. The block does not decode, execute or expand any instruction.

Top module: `cmode_seq`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and the sequencer is in standard mode with no partial word held.
- R2: In standard mode, a halfword whose top five bits `in_data[15:11]` differ from `CMAJ_OP` is the upper half of a 32-bit instruction. The next accepted halfword completes it, and the output shows `{first, second}`, `out_len32`=1 and class 0 (standard).
- R3: In standard mode, a halfword whose `in_data[15:11]` equals `CMAJ_OP` is a 16-bit instruction of class 1 (10-bit mode). With a non-exempt sub-opcode, M=0 keeps standard mode for the next instruction and M=1 switches to 16-bit mode.
- R4: In 16-bit mode, every halfword is a 16-bit instruction. {N,M}=01 gives class 2 and stays in 16-bit mode.
- R5: In 16-bit mode, {N,M}=00 gives class 2, and later halfwords are decoded in standard mode.
- R6: In 16-bit mode, {N,M}=10 gives class 2. Exactly the next two halfwords then form one 32-bit instruction of class 0, with no opcode check on them, and 16-bit mode resumes after it.
- R7: In 16-bit mode, {N,M}=11 gives class 3 (immediate format), and the mode stays 16-bit.
- R8: A compressed halfword whose sub-opcode `in_data[10:8]` is 000 or 111 ignores M and N. It keeps its class (1 in standard mode, 2 in 16-bit mode), and the next instruction is decoded in 16-bit mode.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and the output fields hold steady, so no instruction is lost.
- R10: An instruction appears on the output in the cycle after its last halfword is accepted. A 16-bit instruction sits in `out_insn[15:0]`, and `out_insn[31:16]` is zero.
- R11: `flush` takes priority over acceptance. In the cycle after it, `out_valid` is 0, the mode is standard, any held upper half is dropped and any pending single-instruction escape is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Redirect; returns to standard mode and drops buffered state |
| in_valid | input | 1 | Halfword on `in_data` is valid |
| in_ready | output | 1 | Sequencer accepts a halfword this cycle |
| in_data | input | 16 | Incoming halfword (bit 0 of the numbering is `in_data[15]`) |
| out_valid | output | 1 | An instruction is presented |
| out_ready | input | 1 | Consumer takes the presented instruction |
| out_len32 | output | 1 | 1 for a 32-bit instruction, 0 for 16-bit |
| out_class | output | 2 | 0 standard, 1 10-bit mode, 2 16-bit mode, 3 immediate format |
| out_insn | output | 32 | Instruction bits; compressed ones in the low half |

## Verification
The assertions check, on every cycle, the rules that hold at the output alone: length agrees with class, the upper half is zero on compressed output, the output is held under back-pressure with the input stalled, and the output is empty after a flush. The mode sequence is only visible across several instructions. The one-instruction escape and its automatic return, the exempt sub-opcodes, the choice between the immediate class and a mode exit, and a flush landing between the halves of a 32-bit word are therefore shown only by the bench's directed and random streams, compared against its own model.

// File: rtl/cmode_pkg.sv
package cmode_pkg;

    localparam int HW_W   = 16;
    localparam int INSN_W = 2 * HW_W;
    localparam int MAJ_W  = 5;
    localparam int SUB_W  = 3;

    typedef enum logic [1:0] {
        MODE_STD = 2'd0,
        MODE_C16 = 2'd1,
        MODE_ESC = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        CLS_STD32 = 2'd0,
        CLS_C10   = 2'd1,
        CLS_C16   = 2'd2,
        CLS_IMM   = 2'd3
    } iclass_e;

    typedef struct packed {
        logic    emit;
        logic    hold_upper;
        iclass_e cls;
        mode_e   next_mode;
    } step_t;

    function automatic logic bit_m(input logic [HW_W-1:0] h);
        return h[0];
    endfunction

    function automatic logic bit_n(input logic [HW_W-1:0] h);
        return h[HW_W-1];
    endfunction

    function automatic logic [SUB_W-1:0] sub_op(input logic [HW_W-1:0] h);
        return h[HW_W-6 -: SUB_W];
    endfunction

    function automatic logic is_exempt(input logic [HW_W-1:0] h);
        return (sub_op(h) == '0) || (sub_op(h) == '1);
    endfunction

endpackage

// File: rtl/cmode_classify.sv
module cmode_classify
    import cmode_pkg::*;
#(
    parameter logic [MAJ_W-1:0] CMAJ_OP = 5'b00101
) (
    input  mode_e             mode,
    input  logic              pend,
    input  logic [HW_W-1:0]   hw,
    output step_t             st
);
    logic is_cmaj;
    assign is_cmaj = (hw[HW_W-1 -: MAJ_W] == CMAJ_OP);

    always_comb begin
        st.emit       = 1'b1;
        st.hold_upper = 1'b0;
        st.cls        = CLS_C16;
        st.next_mode  = mode;
        if (pend) begin
            st.cls       = CLS_STD32;
            st.next_mode = (mode == MODE_ESC) ? MODE_C16 : mode;
        end else begin
            unique case (mode)
                MODE_STD: begin
                    if (is_cmaj) begin
                        st.cls = CLS_C10;
                        if (is_exempt(hw) || bit_m(hw)) st.next_mode = MODE_C16;
                        else                            st.next_mode = MODE_STD;
                    end else begin
                        st.emit       = 1'b0;
                        st.hold_upper = 1'b1;
                    end
                end
                MODE_ESC: begin
                    st.emit       = 1'b0;
                    st.hold_upper = 1'b1;
                end
                default: begin
                    if (is_exempt(hw)) begin
                        st.next_mode = MODE_C16;
                    end else begin
                        unique case ({bit_n(hw), bit_m(hw)})
                            2'b01: st.next_mode = MODE_C16;
                            2'b00: st.next_mode = MODE_STD;
                            2'b10: st.next_mode = MODE_ESC;
                            default: begin
                                st.cls       = CLS_IMM;
                                st.next_mode = MODE_C16;
                            end
                        endcase
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/cmode_outreg.sv
module cmode_outreg
    import cmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              load,
    input  logic              len32_in,
    input  iclass_e           cls_in,
    input  logic [INSN_W-1:0] insn_in,
    output logic              can_load,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_len32,
    output logic [1:0]        out_class,
    output logic [INSN_W-1:0] out_insn
);
    assign can_load = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            out_valid <= 1'b0;
            out_len32 <= 1'b0;
            out_class <= 2'd0;
            out_insn  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_len32 <= len32_in;
            out_class <= cls_in;
            out_insn  <= insn_in;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/cmode_seq.sv
module cmode_seq
    import cmode_pkg::*;
#(
    parameter logic [MAJ_W-1:0] CMAJ_OP = 5'b00101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [HW_W-1:0]   in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_len32,
    output logic [1:0]        out_class,
    output logic [INSN_W-1:0] out_insn
);
    mode_e           mode_q;
    logic            pend_q;
    logic [HW_W-1:0] upper_q;
    step_t           st;
    logic            can_load;
    logic            fire;
    logic [INSN_W-1:0] insn_w;

    cmode_classify #(.CMAJ_OP(CMAJ_OP)) u_cls (
        .mode (mode_q),
        .pend (pend_q),
        .hw   (in_data),
        .st   (st)
    );

    assign in_ready = can_load;
    assign fire     = in_valid && can_load && !flush;
    assign insn_w   = pend_q ? {upper_q, in_data} : {{HW_W{1'b0}}, in_data};

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            mode_q  <= MODE_STD;
            pend_q  <= 1'b0;
            upper_q <= '0;
        end else if (fire) begin
            mode_q <= st.next_mode;
            pend_q <= st.hold_upper;
            if (st.hold_upper) upper_q <= in_data;
        end
    end

    cmode_outreg u_out (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .load      (fire && st.emit),
        .len32_in  (pend_q),
        .cls_in    (st.cls),
        .insn_in   (insn_w),
        .can_load  (can_load),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_len32 (out_len32),
        .out_class (out_class),
        .out_insn  (out_insn)
    );
endmodule

// File: rtl/cmode_seq_chk.sv
module cmode_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        flush,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_len32,
    input logic [1:0]  out_class,
    input logic [31:0] out_insn
);
    p_len_class_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_len32 == (out_class == 2'd0)));

    p_upper_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_len32) |-> (out_insn[31:16] == 16'h0));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !flush) |=>
            (out_valid && $stable(out_insn) && $stable(out_class) && $stable(out_len32)));

    p_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    p_flush_r11: assert property (@(posedge clk) disable iff (rst)
        flush |=> !out_valid);
endmodule

bind cmode_seq cmode_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_len32 (out_len32),
    .out_class (out_class),
    .out_insn  (out_insn)
);

// File: tb/tb_cmode_seq.sv
module tb_cmode_seq;
    localparam logic [4:0] CMAJ = 5'b00101;

    logic        clk = 1'b0;
    logic        rst;
    logic        flush;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_data;
    logic        out_valid;
    logic        out_ready;
    logic        out_len32;
    logic [1:0]  out_class;
    logic [31:0] out_insn;

    always #2.5 clk = ~clk;

    cmode_seq #(.CMAJ_OP(CMAJ)) dut (
        .clk(clk), .rst(rst), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_len32(out_len32), .out_class(out_class), .out_insn(out_insn)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference state: 0 standard, 1 16-bit, 2 escape
    int          rmode;
    bit          rpend;
    logic [15:0] rupper;
    logic [34:0] exp_q[$];
    string       tag_q[$];
    bit          last_acc;

    task automatic chk(input bit ok, input string req, input logic [34:0] act, input logic [34:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exempt(input logic [15:0] h);
        return (h[10:8] == 3'b000) || (h[10:8] == 3'b111);
    endfunction

    task automatic push(input bit l32, input logic [1:0] c, input logic [31:0] v, input string t);
        exp_q.push_back({l32, c, v});
        tag_q.push_back(t);
    endtask

    task automatic model_step(input logic [15:0] h);
        if (rpend) begin
            push(1'b1, 2'd0, {rupper, h}, (rmode == 2) ? "R6" : "R2");
            rpend = 0;
            if (rmode == 2) rmode = 1;
        end else if (rmode == 0) begin
            if (h[15:11] == CMAJ) begin
                if (exempt(h)) begin
                    push(1'b0, 2'd1, {16'h0, h}, "R8");
                    rmode = 1;
                end else begin
                    push(1'b0, 2'd1, {16'h0, h}, "R3");
                    rmode = h[0] ? 1 : 0;
                end
            end else begin
                rpend = 1; rupper = h;
            end
        end else if (rmode == 2) begin
            rpend = 1; rupper = h;
        end else begin
            if (exempt(h)) begin
                push(1'b0, 2'd2, {16'h0, h}, "R8");
            end else begin
                case ({h[15], h[0]})
                    2'b01: push(1'b0, 2'd2, {16'h0, h}, "R4");
                    2'b00: begin push(1'b0, 2'd2, {16'h0, h}, "R5"); rmode = 0; end
                    2'b10: begin push(1'b0, 2'd2, {16'h0, h}, "R6"); rmode = 2; end
                    default: push(1'b0, 2'd3, {16'h0, h}, "R7");
                endcase
            end
        end
    endtask

    task automatic cyc(input bit v, input logic [15:0] d, input bit ordy, input bit fl);
        logic [34:0] e;
        string t;
        @(negedge clk);
        in_valid = v; in_data = d; out_ready = ordy; flush = fl;
        #1;
        last_acc = 0;
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", {out_len32, out_class, out_insn}, 35'h0);
            end else begin
                e = exp_q.pop_front(); t = tag_q.pop_front();
                chk({out_len32, out_class, out_insn} == e, t, {out_len32, out_class, out_insn}, e);
            end
        end
        if (in_valid && in_ready && !flush) begin
            last_acc = 1;
            model_step(in_data);
        end
        if (flush) begin
            rmode = 0; rpend = 0;
            exp_q.delete(); tag_q.delete();
        end
    endtask

    task automatic send(input logic [15:0] d);
        cyc(1'b1, d, 1'b1, 1'b0);
    endtask

    function automatic logic [15:0] chw(input bit n, input logic [2:0] sub, input bit m);
        return {n, 4'b0110, sub, 7'b0101010, m};
    endfunction

    initial begin
        #150000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        rmode = 0; rpend = 0; rupper = '0;
        rst = 1; flush = 0; in_valid = 0; in_data = '0; out_ready = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk(!out_valid && in_ready, "R1", {33'h0, out_valid, in_ready}, 35'h1);

        // R2 plain 32-bit word
        send(16'hF123); send(16'h4567);
        // R3 10-bit halfword, M=0 stays standard, then M=1 enters 16-bit mode
        send({CMAJ, 3'b010, 7'h10, 1'b0});
        send({CMAJ, 3'b011, 7'h11, 1'b1});
        // R4 stay, R7 immediate, R8 exempt with N,M=00
        send(chw(1'b0, 3'b010, 1'b1));
        send(chw(1'b1, 3'b100, 1'b1));
        send(chw(1'b0, 3'b000, 1'b0));
        send(chw(1'b0, 3'b111, 1'b0));
        // R6 escape: one 32-bit word whose upper half looks compressed, then back
        send(chw(1'b1, 3'b101, 1'b0));
        send({CMAJ, 11'h7FE}); send(16'hBEEF);
        send(chw(1'b0, 3'b110, 1'b1));
        // R5 exit, then a standard word
        send(chw(1'b0, 3'b011, 1'b0));
        send(16'h1234); send(16'hABCD);
        // R8 exempt 10-bit halfword with M=0 enters 16-bit mode
        send({CMAJ, 3'b111, 7'h00, 1'b0});
        send(chw(1'b0, 3'b010, 1'b0));

        // R10 / R9 latency and stall
        cyc(1'b1, {CMAJ, 3'b010, 7'h33, 1'b0}, 1'b0, 1'b0);
        cyc(1'b1, 16'h2222, 1'b0, 1'b0);
        chk(out_valid == 1'b1, "R10", {34'h0, out_valid}, 35'h1);
        held = out_insn;
        for (int i = 0; i < 3; i++) begin
            chk(!in_ready && out_insn == held, "R9", {2'b0, in_ready, out_insn}, {3'b0, held});
            cyc(1'b1, 16'h2222, 1'b0, 1'b0);
        end
        send(16'h3333);
        send(16'h4444);

        // R11 flush drops upper half and escape
        send(16'h9999);
        cyc(1'b0, 16'h0, 1'b1, 1'b1);
        cyc(1'b0, 16'h0, 1'b1, 1'b0);
        chk(!out_valid, "R11", {34'h0, out_valid}, 35'h0);
        send({CMAJ, 3'b010, 7'h01, 1'b1});
        send(chw(1'b1, 3'b001, 1'b0));
        cyc(1'b0, 16'h0, 1'b1, 1'b1);
        send({CMAJ, 3'b010, 7'h02, 1'b0});
        cyc(1'b0, 16'h0, 1'b1, 1'b0);
        chk(out_valid && out_class == 2'd1, "R11", {32'h0, out_valid, out_class}, {32'h0, 3'b101});

        // random mix
        void'($urandom(32'd1234));
        for (int i = 0; i < 6000; i++) begin
            logic [15:0] h;
            h = $urandom;
            if ($urandom % 3 == 0) h[15:11] = CMAJ;
            cyc(($urandom % 4) != 0, h, ($urandom % 10) < 7, ($urandom % 50) == 0);
        end
        for (int i = 0; i < 4; i++) cyc(1'b0, 16'h0, 1'b1, 1'b0);
        chk(exp_q.size() == 0, "R10", 35'(exp_q.size()), 35'h0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule